// File: doc/BRIEF.md
# I2C-over-Auxiliary-Channel Transaction Sequencer

This block turns single I2C-style bus operations into the short request packets of a display auxiliary channel. A host hands it one operation at a time: set an address (which opens the bus or performs a repeated start), write one byte, read one byte, or stop. The sequencer builds the request for that operation and streams it byte by byte to a channel interface. It then reads the first reply byte and decodes the I2C reply code. Finally it returns completion, an error flag and, for a successful read, the data byte.

Between operations the block keeps the current slave address and a flag that says whether the bus is open. While the bus is open, every request carries a "keep transaction open" bit. A stop is a bare address request with that bit cleared. The sink may answer with a defer code. The sequencer then waits a fixed number of cycles and resends the same request, up to a bounded number of times.

Top module: `aux_i2c_seq`

## Requirements
- R1: An address operation stores `op_addr` and opens the bus. It then sends a 3-byte request: byte 0 = 0x40 | (addr[0] << 4), byte 1 = (addr >> 9) & 0xFF, byte 2 = (addr >> 1) & 0xFF. A new address while the bus is open is sent the same way, as a repeated start.
- R2: A write on an open bus sends 5 bytes: the 3-byte header built from the stored address (with 0x40 set in byte 0), then 0x00, then the data byte. The last byte is marked with `tx_last`.
- R3: A read on an open bus sends 4 bytes: the header, then 0x00. After an ack it takes one more reply byte and returns it on `done_rdata`. In all other cases `done_rdata` is 0.
- R4: A stop on an open bus sends the 3-byte header with bit 6 of byte 0 cleared, and closes the bus. A later write or read is then rejected.
- R5: A stop on a closed bus sends nothing and completes without error.
- R6: A write or read on a closed bus sends nothing and completes with `done_err` = 1.
- R7: The reply code is bits 3:2 of the first reply byte; all other bits are ignored. Code 0 is ack, code 1 is nack and ends with an error, code 3 also ends with an error.
- R8: Code 2 (defer) makes the block resend the identical request. The first byte of the resent request appears on `tx_valid` exactly WAIT_CYC+1 cycles after the cycle in which the defer byte is presented.
- R9: After MAX_RETRY resends, a further defer ends the operation with `done_err` = 1 and no more requests.
- R10: `tx_data` and `tx_last` hold while `tx_valid` is high and `tx_ready` is low. `op_ready` drops in the cycle after an operation is accepted.
- R11: After reset `op_ready` = 1, `tx_valid` = 0 and `done` = 0. `done` is a one-cycle pulse, followed by `op_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation request |
| op_code | input | 2 | 0 address, 1 write, 2 read, 3 stop |
| op_addr | input | AW | 8-bit-style address with read/write in bit 0 (address op only) |
| op_wdata | input | 8 | Byte to write |
| op_ready | output | 1 | Idle, ready to accept an operation |
| done | output | 1 | Operation finished (one cycle) |
| done_err | output | 1 | Operation failed |
| done_rdata | output | 8 | Byte read |
| tx_valid | output | 1 | Request byte valid |
| tx_data | output | 8 | Request byte |
| tx_last | output | 1 | Final byte of request |
| tx_ready | input | 1 | Channel takes the byte |
| rx_valid | input | 1 | Reply byte valid |
| rx_data | input | 8 | Reply byte |

## Verification
Operations are issued in these states: bus closed, bus open with a write address, and bus open after a repeated start to a read address. Seeing the same write give an error in one state and a 5-byte request in another separates the running-flag logic from packet forming. Replies are varied: ack with the low bits set, nack, code 3, defers that later succeed, and defers that exhaust the retry limit. This tells code decoding apart from retry counting. A 10-bit address checks the shifted address bytes, and the channel-ready input stalls every third cycle to test byte holding.

// File: rtl/aux_i2c_seq.sv
module aux_i2c_seq #(
  parameter int AW        = 16,
  parameter int WAIT_CYC  = 400,
  parameter int MAX_RETRY = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  input  logic [1:0]    op_code,
  input  logic [AW-1:0] op_addr,
  input  logic [7:0]    op_wdata,
  output logic          op_ready,
  output logic          done,
  output logic          done_err,
  output logic [7:0]    done_rdata,
  output logic          tx_valid,
  output logic [7:0]    tx_data,
  output logic          tx_last,
  input  logic          tx_ready,
  input  logic          rx_valid,
  input  logic [7:0]    rx_data
);
  localparam int WW = $clog2(WAIT_CYC + 1);
  localparam int RW = $clog2(MAX_RETRY + 2);
  localparam logic [1:0] OP_ADDR = 2'd0, OP_WR = 2'd1, OP_RD = 2'd2, OP_STOP = 2'd3;
  localparam logic [1:0] RC_ACK = 2'd0, RC_DEFER = 2'd2;

  typedef enum logic [2:0] {S_IDLE, S_SEND, S_RECV1, S_RECV2, S_WAIT, S_FIN} st_t;

  st_t           st;
  logic [1:0]    op_q;
  logic [7:0]    wb_q;
  logic [AW-1:0] addr_q;
  logic          run_q;
  logic [2:0]    idx;
  logic [WW-1:0] wcnt;
  logic [RW-1:0] rtry;
  logic          err_q;
  logic [7:0]    rd_q;
  logic [2:0]    len;
  logic          mot;

  assign mot = (op_q != OP_STOP);
  assign len = (op_q == OP_WR) ? 3'd5 : (op_q == OP_RD) ? 3'd4 : 3'd3;

  always_comb begin
    case (idx)
      3'd0:    tx_data = {1'b0, mot, 1'b0, addr_q[0], 4'h0};
      3'd1:    tx_data = 8'(addr_q >> 9);
      3'd2:    tx_data = 8'(addr_q >> 1);
      3'd3:    tx_data = 8'h00;
      default: tx_data = wb_q;
    endcase
  end

  assign op_ready   = (st == S_IDLE);
  assign tx_valid   = (st == S_SEND);
  assign tx_last    = (st == S_SEND) && (idx == len - 3'd1);
  assign done       = (st == S_FIN);
  assign done_err   = err_q;
  assign done_rdata = rd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      op_q   <= OP_ADDR;
      wb_q   <= '0;
      addr_q <= '0;
      run_q  <= 1'b0;
      idx    <= '0;
      wcnt   <= '0;
      rtry   <= '0;
      err_q  <= 1'b0;
      rd_q   <= '0;
    end else begin
      case (st)
        S_IDLE: if (op_valid) begin
          op_q  <= op_code;
          wb_q  <= op_wdata;
          idx   <= '0;
          rtry  <= '0;
          err_q <= 1'b0;
          rd_q  <= '0;
          case (op_code)
            OP_ADDR: begin
              addr_q <= op_addr;
              run_q  <= 1'b1;
              st     <= S_SEND;
            end
            OP_STOP: begin
              run_q <= 1'b0;
              st    <= run_q ? S_SEND : S_FIN;
            end
            default: begin
              err_q <= ~run_q;
              st    <= run_q ? S_SEND : S_FIN;
            end
          endcase
        end
        S_SEND: if (tx_ready) begin
          if (idx == len - 3'd1) begin
            idx <= '0;
            st  <= S_RECV1;
          end else begin
            idx <= idx + 3'd1;
          end
        end
        S_RECV1: if (rx_valid) begin
          if (rx_data[3:2] == RC_ACK) begin
            st <= (op_q == OP_RD) ? S_RECV2 : S_FIN;
          end else if (rx_data[3:2] == RC_DEFER) begin
            if (rtry == RW'(MAX_RETRY)) begin
              err_q <= 1'b1;
              st    <= S_FIN;
            end else begin
              rtry <= rtry + 1'b1;
              wcnt <= '0;
              st   <= S_WAIT;
            end
          end else begin
            err_q <= 1'b1;
            st    <= S_FIN;
          end
        end
        S_RECV2: if (rx_valid) begin
          rd_q <= rx_data;
          st   <= S_FIN;
        end
        S_WAIT: begin
          if (wcnt == WW'(WAIT_CYC - 1)) st <= S_SEND;
          else wcnt <= wcnt + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/aux_i2c_seq_chk.sv
module aux_i2c_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       op_valid,
  input logic       op_ready,
  input logic       done,
  input logic       tx_valid,
  input logic [7:0] tx_data,
  input logic       tx_last,
  input logic       tx_ready
);
  a_r10_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_last));

  a_r10_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_ready |=> !op_ready);

  a_r10_no_send_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> !op_ready && !done);

  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && op_ready);

  a_r2_request_ends: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_ready && tx_last |=> !tx_valid);
endmodule

bind aux_i2c_seq aux_i2c_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
  .done(done), .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last),
  .tx_ready(tx_ready)
);

// File: tb/sim_aux_i2c_seq.sv
`timescale 1ns/1ps
module sim_aux_i2c_seq;
  localparam int WAIT_CYC = 5;
  localparam int MAX_RETRY = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic op_valid = 1'b0;
  logic [1:0] op_code = '0;
  logic [15:0] op_addr = '0;
  logic [7:0] op_wdata = '0;
  logic op_ready, done, done_err, tx_valid, tx_last;
  logic [7:0] done_rdata, tx_data;
  logic tx_ready = 1'b0, rx_valid = 1'b0;
  logic [7:0] rx_data = '0;

  aux_i2c_seq #(.AW(16), .WAIT_CYC(WAIT_CYC), .MAX_RETRY(MAX_RETRY)) u0 (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .op_addr(op_addr), .op_wdata(op_wdata), .op_ready(op_ready), .done(done),
    .done_err(done_err), .done_rdata(done_rdata), .tx_valid(tx_valid),
    .tx_data(tx_data), .tx_last(tx_last), .tx_ready(tx_ready),
    .rx_valid(rx_valid), .rx_data(rx_data));

  always #10 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0, done_cnt = 0;
  string cur_req = "R11";
  logic [8:0] exp_tx[$];
  int rep_q[$];
  logic [8:0] exp_done[$];

  task automatic check(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic push_req(input logic [1:0] op, input logic [15:0] a, input logic [7:0] wd);
    logic mot;
    int n;
    mot = (op != 2'd3);
    n = (op == 2'd1) ? 5 : (op == 2'd2) ? 4 : 3;
    exp_tx.push_back({1'b0, 1'b0, mot, 1'b0, a[0], 4'h0});
    exp_tx.push_back({1'b0, 8'(a >> 9)});
    exp_tx.push_back({n == 3, 8'(a >> 1)});
    if (n > 3) exp_tx.push_back({n == 4, 8'h00});
    if (n > 4) exp_tx.push_back({1'b1, wd});
  endtask

  task automatic push_rep(input int nb, input logic [7:0] b0, input logic [7:0] b1);
    rep_q.push_back((nb << 16) | (int'(b0) << 8) | int'(b1));
  endtask

  task automatic run_op(input string req, input logic [1:0] op, input logic [15:0] a,
                        input logic [7:0] wd, input logic eerr, input logic [7:0] erd);
    int d0;
    cur_req = req;
    exp_done.push_back({eerr, erd});
    @(negedge clk);
    while (!op_ready) @(negedge clk);
    op_valid = 1'b1; op_code = op; op_addr = a; op_wdata = wd;
    d0 = done_cnt;
    @(negedge clk);
    op_valid = 1'b0;
    while (done_cnt == d0) @(negedge clk);
    check(req, exp_tx.size(), 0, "request bytes left unsent");
    check(req, rep_q.size(), 0, "replies left unused");
  endtask

  int rph = 0, rb0 = 0, rb1 = 0, rnb = 0, defer_at = 0;
  bit chk_gap = 0;

  always @(negedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++; checks++;
      $display("FAIL watchdog expired actual=%0d expected<100000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
    if (rst_n) begin
      rx_valid = 1'b0;
      if (rph == 1) begin
        rx_valid = 1'b1; rx_data = 8'(rb0);
        if (rb0[3:2] == 2'd2) begin defer_at = cyc; chk_gap = 1; end
        rph = (rnb == 2) ? 2 : 0;
      end else if (rph == 2) begin
        rx_valid = 1'b1; rx_data = 8'(rb1); rph = 0;
      end
      if (tx_valid && chk_gap) begin
        check("R8", cyc - defer_at, WAIT_CYC + 1, "resend delay after defer");
        chk_gap = 0;
      end
      tx_ready = (cyc % 3 != 0);
      if (tx_valid && tx_ready) begin
        if (exp_tx.size() == 0) begin
          check(cur_req, 1, 0, "unexpected request byte");
        end else begin
          logic [8:0] e;
          e = exp_tx.pop_front();
          check(cur_req, {tx_last, tx_data}, e, "request byte {last,data}");
        end
        if (tx_last) begin
          if (rep_q.size() == 0) check(cur_req, 1, 0, "no reply scripted");
          else begin
            int r;
            r = rep_q.pop_front();
            rnb = r >> 16; rb0 = (r >> 8) & 255; rb1 = r & 255; rph = 1;
          end
        end
      end
      if (done) begin
        chk_gap = 0;
        if (exp_done.size() == 0) check(cur_req, 1, 0, "unexpected done");
        else begin
          logic [8:0] e;
          e = exp_done.pop_front();
          check(cur_req, {done_err, done_rdata}, e, "result {err,rdata}");
        end
        done_cnt++;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R11", {op_ready, tx_valid, done}, 3'b100, "reset {op_ready,tx_valid,done}");

    // R6: write and read while bus closed
    run_op("R6", 2'd1, 16'h0, 8'h11, 1'b1, 8'h00);
    run_op("R6", 2'd2, 16'h0, 8'h00, 1'b1, 8'h00);
    // R5: stop while closed
    run_op("R5", 2'd3, 16'h0, 8'h00, 1'b0, 8'h00);
    // R1: address 0xA0, ack
    push_req(2'd0, 16'h00A0, 8'h00); push_rep(1, 8'h00, 8'h00);
    run_op("R1", 2'd0, 16'h00A0, 8'h00, 1'b0, 8'h00);
    // R2: write, ack with low bits set (R7 ignored bits)
    push_req(2'd1, 16'h00A0, 8'h5A); push_rep(1, 8'h03, 8'h00);
    run_op("R2", 2'd1, 16'h0, 8'h5A, 1'b0, 8'h00);
    // R1: repeated start to read address
    push_req(2'd0, 16'h00A1, 8'h00); push_rep(1, 8'h00, 8'h00);
    run_op("R1", 2'd0, 16'h00A1, 8'h00, 1'b0, 8'h00);
    // R3: read acked
    push_req(2'd2, 16'h00A1, 8'h00); push_rep(2, 8'h00, 8'h3C);
    run_op("R3", 2'd2, 16'h0, 8'h00, 1'b0, 8'h3C);
    // R8: two defers then ack
    push_req(2'd2, 16'h00A1, 8'h00); push_rep(1, 8'h08, 8'h00);
    push_req(2'd2, 16'h00A1, 8'h00); push_rep(1, 8'h08, 8'h00);
    push_req(2'd2, 16'h00A1, 8'h00); push_rep(2, 8'h00, 8'hC7);
    run_op("R8", 2'd2, 16'h0, 8'h00, 1'b0, 8'hC7);
    // R7: nack on write, then code 3 on read
    push_req(2'd1, 16'h00A1, 8'h77); push_rep(1, 8'h04, 8'h00);
    run_op("R7", 2'd1, 16'h0, 8'h77, 1'b1, 8'h00);
    push_req(2'd2, 16'h00A1, 8'h00); push_rep(1, 8'h0C, 8'h00);
    run_op("R7", 2'd2, 16'h0, 8'h00, 1'b1, 8'h00);
    // R9: defers exhaust retries
    for (int i = 0; i <= MAX_RETRY; i++) begin
      push_req(2'd1, 16'h00A1, 8'h99); push_rep(1, 8'h08, 8'h00);
    end
    run_op("R9", 2'd1, 16'h0, 8'h99, 1'b1, 8'h00);
    // R1: wide address shifting
    push_req(2'd0, 16'h03A5, 8'h00); push_rep(1, 8'h00, 8'h00);
    run_op("R1", 2'd0, 16'h03A5, 8'h00, 1'b0, 8'h00);
    // R4: stop on open bus then rejected write
    push_req(2'd3, 16'h03A5, 8'h00); push_rep(1, 8'h00, 8'h00);
    run_op("R4", 2'd3, 16'h0, 8'h00, 1'b0, 8'h00);
    run_op("R4", 2'd1, 16'h0, 8'h42, 1'b1, 8'h00);

    repeat (4) @(negedge clk);
    check("R11", {op_ready, tx_valid, done}, 3'b100, "idle after sequence");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule